// File: doc/BRIEF.md
# 24-bit Integer Multiply Unit

This unit multiplies two 32-bit source words, of which only the low 24 bits take part. Depending on the operation, the operands are read as signed (bit 23 is the sign) or unsigned, and the unit returns either the low 32 bits of the product or its upper part (product bits 47:32) widened to 32 bits. The operation comes from an opcode, and a generation select picks one of two opcode numberings. Each numbering exists in a compact form and in an extended form that is offset by 256.

Operations enter through a valid/ready handshake and leave two register stages later on a valid/ready output. A new operation can be taken on every cycle. The whole pipeline freezes only while the output holds a result that the consumer has not yet taken. An opcode that does not decode still passes through the pipeline. It comes out with a zero result and an illegal-operation flag.

Top module: `imul24_unit`

## Requirements
- R1: Unsigned low product (kind index 2): `out_result` equals the low 32 bits of `in_a[23:0] * in_b[23:0]`. Bits 31:24 of both sources have no effect.
- R2: Signed low product (kind index 0): each source is sign-extended from bit 23, and `out_result` equals the low 32 bits of the signed product.
- R3: Signed high product (kind index 1): `out_result` equals bits 47:32 of the signed 48-bit product, sign-extended to 32 bits.
- R4: Unsigned high product (kind index 3): `out_result` equals bits 47:32 of the unsigned 48-bit product, zero-extended to 32 bits.
- R5: With `in_gen`=0, compact opcodes 9, 10, 11 and 12 select kind indices 0, 1, 2 and 3.
- R6: With `in_gen`=1, compact opcodes 6, 7, 8 and 9 select kind indices 0, 1, 2 and 3.
- R7: In both generations, the extended opcode (compact + 256) selects the same operation as its compact form.
- R8: Any other opcode, including a valid opcode of the other generation, produces `out_illegal`=1 and `out_result`=0. Every recognised opcode produces `out_illegal`=0.
- R9: If an operation is accepted at edge n and `in_ready` is high at edge n+1, then `out_valid` is high right after edge n+1.
- R10: After reset `out_valid`=0 and `in_ready`=1. `in_ready` is low only while `out_valid`=1 and `out_ready`=0, so with `out_ready` held high one operation is accepted every cycle.
- R11: While `out_valid`=1 and `out_ready`=0, the output stays valid and `out_result` and `out_illegal` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The unit takes the offered operation at this edge |
| in_op | input | 9 | Opcode, compact (below 256) or extended form |
| in_gen | input | 1 | Opcode numbering select: 0 first generation, 1 second |
| in_a | input | 32 | First source word |
| in_b | input | 32 | Second source word |
| out_valid | output | 1 | A result is presented |
| out_ready | input | 1 | The consumer takes the result at this edge |
| out_result | output | 32 | Product result |
| out_illegal | output | 1 | The opcode did not decode |

## Verification
Two things can happen in the same cycle: a new operation is offered at the input while the consumer refuses the result at the output. The bench provokes this by dropping `out_ready` while a stream of operations is still being issued. It then checks three things in every such cycle. `in_ready` must be low. The held output must not move. Once `out_ready` returns, every queued result must come out in issue order with its expected value, and none may be lost or duplicated.

// File: rtl/imul24_pkg.sv
`timescale 1ns/1ps
// Shared types for the 24-bit multiply unit.
// Assumes: the kind index order (signed low, signed high, unsigned low,
// unsigned high) matches the opcode order within each generation.
package imul24_pkg;

    typedef enum logic [1:0] {
        KIND_S_LO = 2'd0,
        KIND_S_HI = 2'd1,
        KIND_U_LO = 2'd2,
        KIND_U_HI = 2'd3
    } mul_kind_e;

    typedef struct packed {
        logic legal;
        logic is_signed;
        logic take_high;
    } mul_ctl_t;

endpackage

// File: rtl/imul24_decode.sv
`timescale 1ns/1ps
// Opcode decoder: maps an opcode and a generation select onto the
// control bits of the multiply.
// Assumes: four consecutive compact opcodes per generation, and the
// extended form adds EXT_OFFSET. Purely combinational.
module imul24_decode
    import imul24_pkg::*;
#(
    parameter int OP_W       = 9,
    parameter int EXT_OFFSET = 256,
    parameter int GEN0_BASE  = 9,
    parameter int GEN1_BASE  = 6
) (
    input  logic [OP_W-1:0] op,
    input  logic            gen,
    output mul_ctl_t        ctl
);
    localparam logic [OP_W-1:0] EXT_L   = OP_W'(EXT_OFFSET);
    localparam logic [OP_W-1:0] BASE0_L = OP_W'(GEN0_BASE);
    localparam logic [OP_W-1:0] BASE1_L = OP_W'(GEN1_BASE);

    logic [OP_W-1:0] compact;
    logic [OP_W-1:0] base;
    logic [OP_W-1:0] diff;
    mul_kind_e       kind;

    // Fold the extended form onto the compact one and locate the kind index.
    always_comb begin
        compact   = (op >= EXT_L) ? (op - EXT_L) : op;
        base      = gen ? BASE1_L : BASE0_L;
        diff      = compact - base;
        kind      = mul_kind_e'(diff[1:0]);
        ctl.legal = (compact >= base) && (diff[OP_W-1:2] == '0);
        ctl.is_signed = (kind == KIND_S_LO) || (kind == KIND_S_HI);
        ctl.take_high = (kind == KIND_S_HI) || (kind == KIND_U_HI);
    end

endmodule

// File: rtl/imul24_opnd.sv
`timescale 1ns/1ps
// Operand former: keeps the low OPND_W bits of a source word and adds
// one top bit, which is the sign copy for signed operations and zero
// otherwise. The result is a signed operand one bit wider.
// Assumes: SRC_W >= OPND_W.
module imul24_opnd #(
    parameter int SRC_W  = 32,
    parameter int OPND_W = 24
) (
    input  logic [SRC_W-1:0]         src,
    input  logic                     is_signed,
    output logic signed [OPND_W:0]   opnd
);
    // Drop the upper source bits and attach the extension bit.
    always_comb begin
        opnd = {is_signed & src[OPND_W-1], src[OPND_W-1:0]};
    end

endmodule

// File: rtl/imul24_prod.sv
`timescale 1ns/1ps
// Product and result selection: a signed multiply of two extended
// operands, then either the low RES_W bits or the bits above them,
// sign-extended. For unsigned operands the upper bits are zero, so one
// path covers both sign modes.
// Assumes: 2*(OPND_W+1) > RES_W and 2*(OPND_W+1) - RES_W <= RES_W.
module imul24_prod #(
    parameter int OPND_W = 24,
    parameter int RES_W  = 32
) (
    input  logic signed [OPND_W:0] a,
    input  logic signed [OPND_W:0] b,
    input  logic                   take_high,
    input  logic                   legal,
    output logic [RES_W-1:0]       res
);
    localparam int PROD_W = 2 * (OPND_W + 1);
    localparam int HI_W   = PROD_W - RES_W;

    logic signed [PROD_W-1:0] prod;
    logic signed [HI_W-1:0]   hi_part;
    logic [RES_W-1:0]         hi_ext;

    // Form the product and pick the requested half.
    always_comb begin
        prod    = a * b;
        hi_part = prod[PROD_W-1:RES_W];
        hi_ext  = RES_W'(hi_part);
        if (!legal)
            res = '0;
        else if (take_high)
            res = hi_ext;
        else
            res = prod[RES_W-1:0];
    end

endmodule

// File: rtl/imul24_unit.sv
`timescale 1ns/1ps
// Two-stage 24-bit integer multiply unit. Stage 1 registers the decoded
// control and the formed operands. Stage 2 registers the product result.
// Both stages advance together whenever the output is empty or being
// taken, so in_ready drops only while a result waits at the output.
// Assumes: synchronous active-low reset. Opcodes that do not decode
// travel the pipeline and come out flagged with a zero result.
module imul24_unit
    import imul24_pkg::*;
#(
    parameter int SRC_W      = 32,
    parameter int OPND_W     = 24,
    parameter int OP_W       = 9,
    parameter int EXT_OFFSET = 256,
    parameter int GEN0_BASE  = 9,
    parameter int GEN1_BASE  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [OP_W-1:0]  in_op,
    input  logic             in_gen,
    input  logic [SRC_W-1:0] in_a,
    input  logic [SRC_W-1:0] in_b,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [SRC_W-1:0] out_result,
    output logic             out_illegal
);
    localparam int N_SRC = 2;
    localparam int OPX_W = OPND_W + 1;

    mul_ctl_t                dec_ctl;
    logic [SRC_W-1:0]        src_w [N_SRC];
    logic signed [OPX_W-1:0] opx_w [N_SRC];
    logic [SRC_W-1:0]        prod_res;
    logic                    advance;

    logic                    s1_vld;
    mul_ctl_t                s1_ctl;
    logic signed [OPX_W-1:0] s1_opx [N_SRC];

    logic                    s2_vld;
    logic [SRC_W-1:0]        s2_res;
    logic                    s2_ill;

    // Both stages move when the output is free or is being consumed.
    always_comb begin
        advance  = !s2_vld || out_ready;
        src_w[0] = in_a;
        src_w[1] = in_b;
    end

    imul24_decode #(
        .OP_W       (OP_W),
        .EXT_OFFSET (EXT_OFFSET),
        .GEN0_BASE  (GEN0_BASE),
        .GEN1_BASE  (GEN1_BASE)
    ) u_decode (
        .op  (in_op),
        .gen (in_gen),
        .ctl (dec_ctl)
    );

    for (genvar gi = 0; gi < N_SRC; gi++) begin : g_opnd
        imul24_opnd #(
            .SRC_W  (SRC_W),
            .OPND_W (OPND_W)
        ) u_opnd (
            .src       (src_w[gi]),
            .is_signed (dec_ctl.is_signed),
            .opnd      (opx_w[gi])
        );

        // Stage 1 operand register for this source.
        always_ff @(posedge clk) begin
            if (!rst_n)
                s1_opx[gi] <= '0;
            else if (advance && in_valid)
                s1_opx[gi] <= opx_w[gi];
        end
    end

    // Stage 1 valid and control register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld <= 1'b0;
            s1_ctl <= '0;
        end else if (advance) begin
            s1_vld <= in_valid;
            if (in_valid)
                s1_ctl <= dec_ctl;
        end
    end

    imul24_prod #(
        .OPND_W (OPND_W),
        .RES_W  (SRC_W)
    ) u_prod (
        .a         (s1_opx[0]),
        .b         (s1_opx[1]),
        .take_high (s1_ctl.take_high),
        .legal     (s1_ctl.legal),
        .res       (prod_res)
    );

    // Stage 2 output register, held while the consumer stalls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_vld <= 1'b0;
            s2_res <= '0;
            s2_ill <= 1'b0;
        end else if (advance) begin
            s2_vld <= s1_vld;
            if (s1_vld) begin
                s2_res <= prod_res;
                s2_ill <= !s1_ctl.legal;
            end
        end
    end

    // Drive the ports from the pipeline state.
    always_comb begin
        in_ready    = advance;
        out_valid   = s2_vld;
        out_result  = s2_res;
        out_illegal = s2_ill;
    end

endmodule

// File: rtl/imul24_unit_chk.sv
`timescale 1ns/1ps
// Port-level property checker for the multiply unit, bound to every
// instance of imul24_unit.
// Assumes: synchronous active-low reset on rst_n.
module imul24_unit_chk #(
    parameter int SRC_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [SRC_W-1:0] out_result,
    input logic             out_illegal
);
    AST_LATENCY_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid && in_ready, 2) && $past(in_ready)) |-> out_valid); // R9

    AST_READY_ONLY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> (out_valid && !out_ready)); // R10

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_illegal))); // R11

    AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_illegal) |-> (out_result == '0)); // R8

endmodule

bind imul24_unit imul24_unit_chk #(.SRC_W(SRC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_result  (out_result),
    .out_illegal (out_illegal)
);

// File: tb/imul24_unit_tb.sv
`timescale 1ns/1ps
// Directed bench for imul24_unit: one task per scenario, a reference
// model written from the requirements, and a monitor that compares each
// consumed result against the expectations queued at acceptance.
module imul24_unit_tb;

    logic        clk;
    logic        rst_n;
    logic        in_valid;
    logic        in_ready;
    logic [8:0]  in_op;
    logic        in_gen;
    logic [31:0] in_a;
    logic [31:0] in_b;
    logic        out_valid;
    logic        out_ready;
    logic [31:0] out_result;
    logic        out_illegal;

    int nvec  = 0;
    int nfail = 0;
    int stall_waits = 0;
    bit finished = 0;

    logic [31:0] q_res [$];
    logic        q_ill [$];
    string       q_tag [$];

    logic        prev_hold = 0;
    logic [31:0] prev_res;
    logic        prev_ill;

    imul24_unit u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_op       (in_op),
        .in_gen      (in_gen),
        .in_a        (in_a),
        .in_b        (in_b),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_result  (out_result),
        .out_illegal (out_illegal)
    );

    initial clk = 0;
    always #2.5 clk = ~clk;

    // Reference model taken from the requirement text.
    function automatic void model(input logic [8:0] op, input logic g,
                                  input logic [31:0] a, input logic [31:0] b,
                                  output logic [31:0] r, output logic ill);
        int c, base, k;
        logic [63:0] pa, pb, p;
        c    = (op >= 256) ? int'(op) - 256 : int'(op);
        base = g ? 6 : 9;
        ill  = 1;
        r    = 32'h0;
        if (c >= base && c <= base + 3) begin
            ill = 0;
            k   = c - base;
            if (k < 2) begin
                pa = {{40{a[23]}}, a[23:0]};
                pb = {{40{b[23]}}, b[23:0]};
            end else begin
                pa = {40'h0, a[23:0]};
                pb = {40'h0, b[23:0]};
            end
            p = pa * pb;
            r = (k == 1 || k == 3) ? p[63:32] : p[31:0];
        end
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: samples 1 ns before each rising edge.
    always begin
        @(negedge clk);
        #1.5;
        if (rst_n && !finished) begin
            if (!in_ready)
                check(out_valid && !out_ready, "R10 ready low without stall",
                      {31'h0, out_valid}, 32'h1);
            if (prev_hold) begin
                check(out_valid && out_result == prev_res && out_illegal == prev_ill,
                      "R11 held output moved", out_result, prev_res);
            end
            prev_hold = out_valid && !out_ready;
            prev_res  = out_result;
            prev_ill  = out_illegal;
            if (out_valid && out_ready) begin
                if (q_res.size() == 0) begin
                    check(0, "R9 unexpected output", out_result, 32'h0);
                end else begin
                    logic [31:0] er; logic ei; string t;
                    er = q_res.pop_front();
                    ei = q_ill.pop_front();
                    t  = q_tag.pop_front();
                    check(out_result == er && out_illegal == ei, t,
                          {out_illegal, out_result[30:0]}, {ei, er[30:0]});
                    if (out_result[31] != er[31])
                        check(0, t, out_result, er);
                end
            end
        end
    end

    // Offer one operation from a falling edge until accepted; returns at a falling edge.
    task automatic issue(input logic [8:0] op, input logic g, input logic [31:0] a,
                         input logic [31:0] b, input string tag);
        logic [31:0] r; logic il; bit acc;
        model(op, g, a, b, r, il);
        in_valid = 1; in_op = op; in_gen = g; in_a = a; in_b = b;
        acc = 0;
        while (!acc) begin
            #1.5;
            acc = in_ready;
            if (acc) begin
                q_res.push_back(r); q_ill.push_back(il); q_tag.push_back(tag);
            end else begin
                stall_waits++;
            end
            @(negedge clk);
        end
    endtask

    task automatic idle();
        in_valid = 0;
        in_op = '0; in_a = '0; in_b = '0;
    endtask

    task automatic drain(input string tag);
        idle();
        for (int i = 0; i < 40 && q_res.size() != 0; i++) @(negedge clk);
        repeat (2) @(negedge clk);
        check(q_res.size() == 0, tag, q_res.size(), 32'h0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(out_valid == 0, "R10 out_valid after reset", {31'h0, out_valid}, 32'h0);
        check(in_ready == 1, "R10 in_ready after reset", {31'h0, in_ready}, 32'h1);
    endtask

    task automatic t_unsigned_low();
        issue(9'd11, 0, 32'hFF00_0003, 32'hAB00_0005, "R1 upper bits ignored");
        issue(9'd11, 0, 32'h00FF_FFFF, 32'h12FF_FFFF, "R1 max operands");
        issue(9'd8,  1, 32'h0080_0000, 32'h0000_0002, "R1 bit23 unsigned");
        drain("R1 drain");
    endtask

    task automatic t_signed_low();
        issue(9'd9, 0, 32'h00FF_FFFF, 32'h0000_0007, "R2 minus one times seven");
        issue(9'd9, 0, 32'h5580_0000, 32'h0080_0000, "R2 most negative squared");
        issue(9'd6, 1, 32'hFF12_3456, 32'h00FF_FFFE, "R2 upper bits ignored");
        drain("R2 drain");
    endtask

    task automatic t_signed_high();
        issue(9'd10, 0, 32'h0080_0000, 32'h007F_FFFF, "R3 negative high");
        issue(9'd10, 0, 32'h007F_FFFF, 32'h007F_FFFF, "R3 positive high");
        issue(9'd7,  1, 32'hAAFF_FFFF, 32'h0000_0003, "R3 small negative");
        drain("R3 drain");
    endtask

    task automatic t_unsigned_high();
        issue(9'd12, 0, 32'h00FF_FFFF, 32'h00FF_FFFF, "R4 max high");
        issue(9'd9,  1, 32'hFF80_0000, 32'h0080_0000, "R4 no sign extension");
        drain("R4 drain");
    endtask

    task automatic t_gen0_map();
        for (int k = 0; k < 4; k++)
            issue(9'(9 + k), 0, 32'h00C0_1234, 32'h00B0_5678, "R5 gen0 opcode map");
        drain("R5 drain");
    endtask

    task automatic t_gen1_map();
        for (int k = 0; k < 4; k++)
            issue(9'(6 + k), 1, 32'h00C0_1234, 32'h00B0_5678, "R6 gen1 opcode map");
        drain("R6 drain");
    endtask

    task automatic t_extended();
        for (int k = 0; k < 4; k++) begin
            issue(9'(265 + k), 0, 32'h0091_0203, 32'h00E4_0506, "R7 gen0 extended");
            issue(9'(262 + k), 1, 32'h0091_0203, 32'h00E4_0506, "R7 gen1 extended");
        end
        drain("R7 drain");
    endtask

    task automatic t_illegal();
        issue(9'd8,   0, 32'h0000_1111, 32'h0000_2222, "R8 below gen0 range");
        issue(9'd13,  0, 32'h0000_1111, 32'h0000_2222, "R8 above gen0 range");
        issue(9'd5,   1, 32'h0000_1111, 32'h0000_2222, "R8 below gen1 range");
        issue(9'd10,  1, 32'h0000_1111, 32'h0000_2222, "R8 above gen1 range");
        issue(9'd12,  1, 32'h0000_1111, 32'h0000_2222, "R8 gen0 code under gen1");
        issue(9'd6,   0, 32'h0000_1111, 32'h0000_2222, "R8 gen1 code under gen0");
        issue(9'd269, 0, 32'h0000_1111, 32'h0000_2222, "R8 extended out of range");
        issue(9'd100, 0, 32'h0000_1111, 32'h0000_2222, "R8 unrelated opcode");
        drain("R8 drain");
    endtask

    task automatic t_latency();
        logic [31:0] r; logic il;
        model(9'd11, 0, 32'd6, 32'd7, r, il);
        in_valid = 1; in_op = 9'd11; in_gen = 0; in_a = 32'd6; in_b = 32'd7;
        #1.5;
        check(in_ready == 1, "R9 accepted", {31'h0, in_ready}, 32'h1);
        q_res.push_back(r); q_ill.push_back(il); q_tag.push_back("R9 latency value");
        @(negedge clk);
        idle();
        #1.5;
        check(out_valid == 0, "R9 not valid after one edge", {31'h0, out_valid}, 32'h0);
        @(negedge clk);
        #1.5;
        check(out_valid == 1, "R9 valid after two edges", {31'h0, out_valid}, 32'h1);
        @(negedge clk);
        drain("R9 drain");
    endtask

    task automatic t_stream();
        int w0;
        w0 = stall_waits;
        for (int k = 0; k < 8; k++)
            issue(9'(9 + (k % 4)), 0, 32'h0012_3400 + 32'(k * 77), 32'h00F0_0001 + 32'(k), "R10 stream value");
        check(stall_waits == w0, "R10 back-to-back acceptance", stall_waits - w0, 32'h0);
        drain("R10 drain");
    endtask

    task automatic t_stall();
        int w0;
        w0 = stall_waits;
        out_ready = 0;
        fork
            begin
                for (int k = 0; k < 4; k++)
                    issue(9'(6 + k), 1, 32'h0040_0000 + 32'(k), 32'h00FF_FFF0 - 32'(k), "R11 order after stall");
                idle();
            end
            begin
                repeat (6) @(negedge clk);
                out_ready = 1;
            end
        join
        check(stall_waits > w0, "R10 input held during stall", stall_waits - w0, 32'h1);
        drain("R11 drain");
    endtask

    task automatic finish_run();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    endtask

    initial begin
        rst_n = 0; out_ready = 1; in_gen = 0;
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_unsigned_low();
        t_signed_low();
        t_signed_high();
        t_unsigned_high();
        t_gen0_map();
        t_gen1_map();
        t_extended();
        t_illegal();
        t_latency();
        t_stream();
        t_stall();
        finish_run();
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            nvec++; nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule